// File: doc/BRIEF.md
# Transparent Translation Window Matcher

This block decides, for every logical address presented to it, whether the access falls inside one of the transparent windows and so skips page-table translation. It holds four window registers: two serve data accesses and two serve instruction accesses. Each window names one value of the top address byte. A per-window mask turns any of those byte bits into don't-care. An optional privilege qualifier restricts the window to user or to supervisor accesses. The verdict is combinational: it appears in the same cycle as the address. It can be a miss, a hit, or a hit on which writes are refused.

Software or a control sequencer loads the windows through a register write port. A second path, the fill helper, takes a base address and a size and places a window into a free register of the chosen bank. The fill helper tries the second register of the bank before the first. It writes nothing when both registers are already enabled. All four registers can be read back at all times.

Top module: `xlat_window_match`

## Requirements
- R1: While reset is asserted, all four window registers read back as zero, and the verdict is 2'b00.
- R2: A window whose enable bit (bit 15) is clear never produces a hit.
- R3: A window hits on the address only when every bit of address[31:24] equals the matching bit of window[31:24]. The exception is any bit whose mask bit in window[23:16] is set: that bit is ignored.
- R4: When the privilege-ignore bit (bit 14) is clear, a hit also requires the privilege-select bit (bit 13) to equal `lookup_super`. When bit 14 is set, the privilege of the access is ignored.
- R5: The verdict is 2'b00 for a miss and 2'b01 for a hit. It is 2'b10 for a hit on a window whose write-protect bit (bit 2) is set. It is never 2'b11.
- R6: With `lookup_data`=1 the data windows (select 0, then select 1) are consulted. With `lookup_data`=0 the instruction windows (select 2, then select 3) are consulted. The second window of a bank decides only when the first window misses.
- R7: A write with `wr_en`=1 stores `wr_value` into the window chosen by `wr_sel` (0 = data 0, 1 = data 1, 2 = instruction 0, 3 = instruction 1). The new value reads back after the next rising clock edge.
- R8: A fill request stores into the second window of the chosen bank if that window is disabled. Otherwise it stores into the first window if that one is disabled. Otherwise nothing changes. The stored word holds base[31:24] in bits 31:24 and (base+size-1)[31:24] in bits 23:16, has bit 15 set, and has all other bits zero.
- R9: When `wr_en` and `prog_en` are both high in one cycle, the write is performed and the fill request is dropped.
- R10: The verdict follows the address, privilege and bank inputs in the same cycle. A register change alters the verdict only from the clock edge that stores it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lookup_addr | input | 32 | Logical address under test |
| lookup_super | input | 1 | 1 for a supervisor access |
| lookup_data | input | 1 | 1 for a data access, 0 for an instruction fetch |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register chosen for the write |
| wr_value | input | 32 | Value written |
| prog_en | input | 1 | Fill helper request |
| prog_data | input | 1 | Bank for the fill: 1 data, 0 instruction |
| prog_base | input | 32 | Window start address for the fill |
| prog_size | input | 32 | Window length in bytes for the fill |
| rd_win0 | output | 32 | Data window 0 contents |
| rd_win1 | output | 32 | Data window 1 contents |
| rd_win2 | output | 32 | Instruction window 0 contents |
| rd_win3 | output | 32 | Instruction window 1 contents |
| match_code | output | 2 | Verdict: 00 miss, 01 hit, 10 hit with writes refused |

## Verification
The verdict is due in the same cycle as the address, privilege and bank inputs, with zero register delay. A write or fill shows on the read-back ports, and in the verdict, one rising edge after the cycle that requests it. The bench drives every input just after a falling edge and compares shortly afterwards, before the next rising edge. At that point the model's register copy still holds the state from before the request. The model applies the request's effect only after the comparison, so the change is expected exactly one edge later.

// File: rtl/bwin_pkg.sv
package bwin_pkg;
  localparam int WORD_W   = 32;
  localparam int FIELD_W  = 8;
  localparam int BASE_LSB = 24;
  localparam int MASK_LSB = 16;
  localparam int EN_BIT   = 15;
  localparam int PIGN_BIT = 14;
  localparam int PSEL_BIT = 13;
  localparam int WP_BIT   = 2;
  localparam int NUM_WIN  = 4;
  localparam int PER_BANK = 2;
  localparam int SEL_W    = $clog2(NUM_WIN);

  typedef enum logic [1:0] {
    RES_MISS   = 2'b00,
    RES_HIT    = 2'b01,
    RES_HIT_RO = 2'b10
  } win_res_e;

  // Word produced by the fill helper from a start address and a length.
  function automatic logic [WORD_W-1:0] pack_window(input logic [WORD_W-1:0] base,
                                                    input logic [WORD_W-1:0] size);
    logic [WORD_W-1:0] last;
    logic [WORD_W-1:0] w;
    last = base + size - WORD_W'(1);
    w = '0;
    w[BASE_LSB +: FIELD_W] = base[BASE_LSB +: FIELD_W];
    w[MASK_LSB +: FIELD_W] = last[BASE_LSB +: FIELD_W];
    w[EN_BIT] = 1'b1;
    return w;
  endfunction

  // True when the address top byte agrees with the window outside its mask.
  function automatic logic byte_agrees(input logic [WORD_W-1:0] addr,
                                       input logic [WORD_W-1:0] win);
    logic [FIELD_W-1:0] diff;
    diff = (addr[BASE_LSB +: FIELD_W] ^ win[BASE_LSB +: FIELD_W]) &
           ~win[MASK_LSB +: FIELD_W];
    return diff == '0;
  endfunction
endpackage

// File: rtl/bwin_regs.sv
module bwin_regs
  import bwin_pkg::*;
(
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wr_en,
  input  logic [SEL_W-1:0]                wr_sel,
  input  logic [WORD_W-1:0]               wr_value,
  input  logic                            prog_en,
  input  logic                            prog_data,
  input  logic [WORD_W-1:0]               prog_base,
  input  logic [WORD_W-1:0]               prog_size,
  output logic [NUM_WIN-1:0][WORD_W-1:0]  win_q,
  output logic                            prog_fire,
  output logic [SEL_W-1:0]                prog_idx
);
  logic [SEL_W-1:0]  bank_lo;
  logic [SEL_W-1:0]  bank_hi;
  logic [WORD_W-1:0] prog_word;

  assign bank_lo   = prog_data ? SEL_W'(0) : SEL_W'(PER_BANK);
  assign bank_hi   = bank_lo + SEL_W'(1);
  assign prog_word = pack_window(prog_base, prog_size);

  // Second register of the bank is preferred; an explicit write wins.
  always_comb begin
    prog_fire = 1'b0;
    prog_idx  = bank_hi;
    if (prog_en && !wr_en) begin
      if (!win_q[bank_hi][EN_BIT]) begin
        prog_fire = 1'b1;
        prog_idx  = bank_hi;
      end else if (!win_q[bank_lo][EN_BIT]) begin
        prog_fire = 1'b1;
        prog_idx  = bank_lo;
      end
    end
  end

  for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        win_q[g] <= '0;
      end else if (wr_en && wr_sel == SEL_W'(g)) begin
        win_q[g] <= wr_value;
      end else if (prog_fire && prog_idx == SEL_W'(g)) begin
        win_q[g] <= prog_word;
      end
    end
  end
endmodule

// File: rtl/bwin_match.sv
module bwin_match
  import bwin_pkg::*;
(
  input  logic [WORD_W-1:0] win,
  input  logic [WORD_W-1:0] addr,
  input  logic              sup,
  output win_res_e          res,
  output logic              addr_hit,
  output logic              priv_ok
);
  assign addr_hit = byte_agrees(addr, win);
  assign priv_ok  = win[PIGN_BIT] || (win[PSEL_BIT] == sup);

  always_comb begin
    res = RES_MISS;
    if (win[EN_BIT] && addr_hit && priv_ok)
      res = win[WP_BIT] ? RES_HIT_RO : RES_HIT;
  end
endmodule

// File: rtl/bwin_pick.sv
module bwin_pick
  import bwin_pkg::*;
(
  input  win_res_e [NUM_WIN-1:0] res,
  input  logic                   data_sel,
  output win_res_e               code,
  output logic                   first_hit
);
  win_res_e lo_res;
  win_res_e hi_res;

  assign lo_res    = data_sel ? res[0] : res[PER_BANK];
  assign hi_res    = data_sel ? res[1] : res[PER_BANK+1];
  assign first_hit = lo_res != RES_MISS;
  assign code      = first_hit ? lo_res : hi_res;
endmodule

// File: rtl/xlat_window_match.sv
module xlat_window_match
  import bwin_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] lookup_addr,
  input  logic        lookup_super,
  input  logic        lookup_data,
  input  logic        wr_en,
  input  logic [1:0]  wr_sel,
  input  logic [31:0] wr_value,
  input  logic        prog_en,
  input  logic        prog_data,
  input  logic [31:0] prog_base,
  input  logic [31:0] prog_size,
  output logic [31:0] rd_win0,
  output logic [31:0] rd_win1,
  output logic [31:0] rd_win2,
  output logic [31:0] rd_win3,
  output logic [1:0]  match_code
);
  logic [NUM_WIN-1:0][WORD_W-1:0] win_q;
  logic                           prog_fire;
  logic [SEL_W-1:0]               prog_idx;
  win_res_e [NUM_WIN-1:0]         win_res;
  logic [NUM_WIN-1:0]             win_addr_hit;
  logic [NUM_WIN-1:0]             win_priv_ok;
  win_res_e                       code;
  logic                           first_hit;

  bwin_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .wr_value  (wr_value),
    .prog_en   (prog_en),
    .prog_data (prog_data),
    .prog_base (prog_base),
    .prog_size (prog_size),
    .win_q     (win_q),
    .prog_fire (prog_fire),
    .prog_idx  (prog_idx)
  );

  for (genvar g = 0; g < NUM_WIN; g++) begin : g_cmp
    bwin_match u_match (
      .win      (win_q[g]),
      .addr     (lookup_addr),
      .sup      (lookup_super),
      .res      (win_res[g]),
      .addr_hit (win_addr_hit[g]),
      .priv_ok  (win_priv_ok[g])
    );
  end

  bwin_pick u_pick (
    .res       (win_res),
    .data_sel  (lookup_data),
    .code      (code),
    .first_hit (first_hit)
  );

  assign match_code = code;
  assign rd_win0    = win_q[0];
  assign rd_win1    = win_q[1];
  assign rd_win2    = win_q[2];
  assign rd_win3    = win_q[3];
endmodule

// File: rtl/bwin_checker.sv
module bwin_checker
  import bwin_pkg::*;
(
  input logic                           clk,
  input logic                           rst_n,
  input logic                           lookup_data,
  input logic                           wr_en,
  input logic [1:0]                     wr_sel,
  input logic [31:0]                    wr_value,
  input logic                           prog_en,
  input logic                           prog_data,
  input logic [31:0]                    prog_base,
  input logic [31:0]                    prog_size,
  input logic [1:0]                     match_code,
  input logic [NUM_WIN-1:0][WORD_W-1:0] win_q
);
  logic [WORD_W-1:0] lo_w, hi_w, plo_w, phi_w;
  assign lo_w  = lookup_data ? win_q[0] : win_q[2];
  assign hi_w  = lookup_data ? win_q[1] : win_q[3];
  assign plo_w = prog_data ? win_q[0] : win_q[2];
  assign phi_w = prog_data ? win_q[1] : win_q[3];

  p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> win_q == '0);

  p_disabled_miss_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!lo_w[EN_BIT] && !hi_w[EN_BIT]) |-> match_code == 2'b00);

  p_legal_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
    match_code != 2'b11);

  p_ro_needs_wp_r5: assert property (@(posedge clk) disable iff (!rst_n)
    match_code == 2'b10 |->
      ((lo_w[EN_BIT] && lo_w[WP_BIT]) || (hi_w[EN_BIT] && hi_w[WP_BIT])));

  p_write_lands_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> win_q[$past(wr_sel)] == $past(wr_value));

  p_fill_second_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_en && !wr_en && !phi_w[EN_BIT]) |=>
      (($past(prog_data) ? win_q[1] : win_q[3]) ==
       pack_window($past(prog_base), $past(prog_size))));

  p_full_bank_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_en && !wr_en && plo_w[EN_BIT] && phi_w[EN_BIT]) |=> $stable(win_q));
endmodule

bind xlat_window_match bwin_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .lookup_data (lookup_data),
  .wr_en       (wr_en),
  .wr_sel      (wr_sel),
  .wr_value    (wr_value),
  .prog_en     (prog_en),
  .prog_data   (prog_data),
  .prog_base   (prog_base),
  .prog_size   (prog_size),
  .match_code  (match_code),
  .win_q       (win_q)
);

// File: tb/test_xlat_window_match.sv
module test_xlat_window_match;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] lookup_addr = '0;
  logic        lookup_super = 1'b0;
  logic        lookup_data = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = '0;
  logic [31:0] wr_value = '0;
  logic        prog_en = 1'b0;
  logic        prog_data = 1'b0;
  logic [31:0] prog_base = '0;
  logic [31:0] prog_size = '0;
  logic [31:0] rd_win0, rd_win1, rd_win2, rd_win3;
  logic [1:0]  match_code;

  int checks = 0;
  int errors = 0;
  logic done = 1'b0;
  logic [31:0] m [4];

  always #(CLK_PERIOD/2) clk = ~clk;

  xlat_window_match i_xlat_window_match (
    .clk(clk), .rst_n(rst_n), .lookup_addr(lookup_addr), .lookup_super(lookup_super),
    .lookup_data(lookup_data), .wr_en(wr_en), .wr_sel(wr_sel), .wr_value(wr_value),
    .prog_en(prog_en), .prog_data(prog_data), .prog_base(prog_base), .prog_size(prog_size),
    .rd_win0(rd_win0), .rd_win1(rd_win1), .rd_win2(rd_win2), .rd_win3(rd_win3),
    .match_code(match_code)
  );

  // Behavioural verdict for one window, bit by bit.
  function automatic int one_window(logic [31:0] r, logic [31:0] a, logic s);
    if (r[15] == 1'b0) return 0;
    for (int b = 0; b < 8; b++)
      if (!r[16+b] && (r[24+b] != a[24+b])) return 0;
    if (!r[14] && (r[13] != s)) return 0;
    return r[2] ? 2 : 1;
  endfunction

  function automatic int expect_code(logic [31:0] a, logic s, logic d);
    int first;
    first = d ? 0 : 2;
    if (one_window(m[first], a, s) != 0) return one_window(m[first], a, s);
    return one_window(m[first+1], a, s);
  endfunction

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all(string tag);
    check(tag, "match_code", 32'(match_code), 32'(expect_code(lookup_addr, lookup_super, lookup_data)));
    check(tag, "rd_win0", rd_win0, m[0]);
    check(tag, "rd_win1", rd_win1, m[1]);
    check(tag, "rd_win2", rd_win2, m[2]);
    check(tag, "rd_win3", rd_win3, m[3]);
  endtask

  // One cycle: drive after the falling edge, compare before the rising edge,
  // then apply the request to the model (it takes effect at that rising edge).
  task automatic cyc(logic we, logic [1:0] ws, logic [31:0] wv,
                     logic pe, logic pd, logic [31:0] pb, logic [31:0] ps,
                     logic [31:0] a, logic s, logic d, string tag);
    logic [31:0] last;
    int lo;
    @(negedge clk);
    wr_en = we; wr_sel = ws; wr_value = wv;
    prog_en = pe; prog_data = pd; prog_base = pb; prog_size = ps;
    lookup_addr = a; lookup_super = s; lookup_data = d;
    #1;
    compare_all(tag);
    if (we) m[ws] = wv;
    else if (pe) begin
      lo = pd ? 0 : 2;
      last = pb + ps - 32'd1;
      if (!m[lo+1][15]) m[lo+1] = {pb[31:24], last[31:24], 16'h8000};
      else if (!m[lo][15]) m[lo] = {pb[31:24], last[31:24], 16'h8000};
    end
  endtask

  task automatic wr(logic [1:0] sel, logic [31:0] v, string tag);
    cyc(1'b1, sel, v, 1'b0, 1'b0, '0, '0, 32'h0, 1'b0, 1'b1, tag);
  endtask

  task automatic look(logic [31:0] a, logic s, logic d, string tag);
    cyc(1'b0, 2'd0, '0, 1'b0, 1'b0, '0, '0, a, s, d, tag);
  endtask

  task automatic fill(logic d, logic [31:0] b, logic [31:0] sz, string tag);
    cyc(1'b0, 2'd0, '0, 1'b1, d, b, sz, b, 1'b0, d, tag);
  endtask

  initial begin
    for (int i = 0; i < 4; i++) m[i] = '0;
    repeat (3) @(negedge clk);
    lookup_addr = 32'h4000_0000; lookup_data = 1'b1;
    #1;
    compare_all("R1"); // reset state
    @(negedge clk);
    rst_n = 1'b1;

    // R3 / R7: exact top byte, privilege ignored
    wr(2'd0, 32'h4000_C000, "R7");
    look(32'h4012_3456, 1'b0, 1'b1, "R3");
    look(32'h4112_3456, 1'b0, 1'b1, "R3");
    // R3: low nibble of the byte masked
    wr(2'd0, 32'h400F_C000, "R7");
    look(32'h4F00_0000, 1'b1, 1'b1, "R3");
    look(32'h5000_0000, 1'b1, 1'b1, "R3");
    // R2: same window but disabled
    wr(2'd0, 32'h400F_4000, "R2");
    look(32'h4000_0000, 1'b1, 1'b1, "R2");
    // R4: supervisor-only window
    wr(2'd0, 32'h4000_A000, "R4");
    look(32'h4000_0000, 1'b1, 1'b1, "R4");
    look(32'h4000_0000, 1'b0, 1'b1, "R4");
    // R5: write-protected window
    wr(2'd0, 32'h4000_C004, "R5");
    look(32'h4000_1000, 1'b0, 1'b1, "R5");
    // R6: bank choice and order
    look(32'h4000_1000, 1'b0, 1'b0, "R6");
    wr(2'd1, 32'h4000_C000, "R6");
    look(32'h4000_1000, 1'b0, 1'b1, "R6");
    wr(2'd0, 32'h7700_C004, "R6");
    look(32'h4000_1000, 1'b0, 1'b1, "R6");
    wr(2'd3, 32'h2000_C004, "R6");
    look(32'h2000_0000, 1'b0, 1'b0, "R6");
    wr(2'd2, 32'h2000_C000, "R6");
    look(32'h2000_0000, 1'b0, 1'b0, "R6");
    // R10: verdict changes only from the storing edge
    cyc(1'b1, 2'd2, 32'h0, 1'b0, 1'b0, '0, '0, 32'h2000_0000, 1'b0, 1'b0, "R10");
    look(32'h2000_0000, 1'b0, 1'b0, "R10");
    // R8: fill helper order and full bank
    for (int i = 0; i < 4; i++) wr(2'(i), 32'h0, "R7");
    fill(1'b1, 32'h1000_0000, 32'h0300_0000, "R8");
    fill(1'b1, 32'h3000_0000, 32'h0100_0000, "R8");
    fill(1'b1, 32'h5000_0000, 32'h0100_0000, "R8");
    look(32'h1200_0000, 1'b0, 1'b1, "R8");
    look(32'h3000_0000, 1'b0, 1'b1, "R8");
    // R9: write wins over fill in the same cycle
    cyc(1'b1, 2'd2, 32'h6600_C000, 1'b1, 1'b0, 32'h8000_0000, 32'h100, 32'h6600_0000, 1'b0, 1'b0, "R9");
    look(32'h6600_0000, 1'b0, 1'b0, "R9");

    // Mixed stimulus against the model
    for (int n = 0; n < 600; n++) begin
      logic [31:0] a, v;
      logic [7:0] tb;
      int k;
      k = int'($urandom_range(0, 9));
      v = $urandom;
      v[15] = ($urandom_range(0, 3) != 0);
      v[23:16] = ($urandom_range(0, 1) != 0) ? 8'h00 : v[23:16] & 8'h0F;
      tb = (k < 3) ? m[k % 4][31:24] : 8'($urandom);
      a = {tb ^ 8'($urandom_range(0, 3)), 24'($urandom)};
      if (k == 0)
        cyc(1'b1, 2'($urandom), v, $urandom_range(0, 1) != 0, 1'($urandom), $urandom,
            $urandom, a, 1'($urandom), 1'($urandom), "R7");
      else if (k == 1)
        cyc(1'b0, 2'd0, '0, 1'b1, 1'($urandom), $urandom, $urandom,
            a, 1'($urandom), 1'($urandom), "R8");
      else
        look(a, 1'($urandom), 1'($urandom), "R6");
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule